// File: doc/BRIEF.md
# Power-Management Interrupt Cause/Mask Unit

This unit gathers seven level-sensitive event lines from a power-management block into one interrupt request for a parent interrupt controller. Every event line feeds a sticky cause bit. A mask register enables or disables each source. The combined request is raised whenever a pending cause bit is also enabled in the mask.

Software uses a simple strobe-based register port to read and write both registers. The cause register is ordinary read/write storage. A written 1 sets a pending bit and a written 0 clears it. Software therefore acknowledges events with a read-modify-write. An event that lands between the read and the write-back, and is gone by the write cycle, is overwritten and lost. The bench reproduces this window on purpose.

Top module: `pmirq_unit`

## Requirements
- R1: After a synchronous active-low reset, the cause register reads 0, the mask register reads 0 and `irq_o` is low.
- R2: Any clock edge at which event line k (0 to 6) is high sets cause bit k. The bit stays set after the line falls, until software writes 0 to it.
- R3: A write to byte offset 0x50 loads cause bits 0 to 6 with exactly data bits 0 to 6. A 1 sets a pending bit and a 0 clears it.
- R4: If a hardware event on line k arrives in the same cycle as a software write of 0 to cause bit k, the bit ends up 1.
- R5: A write to byte offset 0x54 loads mask bits 0 to 6 from data bits 0 to 6. A mask bit of 1 enables its source. Bits 7 to 31 of both registers read as 0, and writes to them have no effect.
- R6: `irq_o` is registered. After the edge at which (cause AND mask) becomes non-zero, `irq_o` goes high on the next edge. After the edge at which it becomes zero, `irq_o` goes low on the next edge.
- R7: Reads have no side effect: reading the cause register leaves its contents and `irq_o` unchanged.
- R8: Writes to any offset other than 0x50 and 0x54 change nothing. Reads of those offsets return 0. `rd_data` is 0 whenever `rd_en` is low.
- R9: Consider a read-modify-write clear that writes back 0 for bit k. If an event on line k occurs after the read and is low during the write cycle, that event is lost and bit k reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 7 | Level-sensitive event lines, bit k is source k |
| wr_en | input | 1 | Write strobe, sampled at the clock edge |
| rd_en | input | 1 | Read strobe, read data is returned combinationally |
| addr | input | 8 | Byte offset in the register window |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data, 0 when no read is selected |
| irq_o | output | 1 | Registered combined interrupt request |

## Verification
Suppose a cause bit is stuck, or is cleared when it should be set. A cause read exposes the error right away, and `irq_o` shows it one edge later when that source is unmasked. A mask bit held at the wrong value makes `irq_o` disagree with the written pattern on the cycle after the second write. That is why the bench sweeps all 128 by 128 combinations of mask and cause. Priority faults between hardware and software updates show up only in the cycle where both act together. For this reason the collision and the lost-event window are driven with exact cycle alignment.

// File: rtl/pmirq_pkg.sv
// Package: shared sizes and register offsets for the interrupt cause/mask unit.
// Assumes byte addressing within an 8-bit register window.
package pmirq_pkg;
    localparam int unsigned SRC_N     = 7;
    localparam int unsigned DATA_W    = 32;
    localparam int unsigned ADDR_W    = 8;
    localparam logic [7:0]  CAUSE_OFS = 8'h50;
    localparam logic [7:0]  MASK_OFS  = 8'h54;
endpackage

// File: rtl/pmirq_cause_reg.sv
// Cause register: one sticky bit per event source.
// Each bit is set by a high event level at a clock edge and loaded by software writes.
// If both act on a bit in the same cycle, the hardware set wins.
// Assumes the event lines are already synchronous to clk.
module pmirq_cause_reg #(
    parameter int unsigned SRC_N = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] evt_i,
    input  logic             wr_i,
    input  logic [SRC_N-1:0] wdata_i,
    output logic [SRC_N-1:0] cause_o
);
    logic [SRC_N-1:0] cause_q;

    for (genvar k = 0; k < SRC_N; k++) begin : g_bit
        // Per-bit update: reset clears, a software write loads, an event forces 1.
        always_ff @(posedge clk) begin
            if (!rst_n)
                cause_q[k] <= 1'b0;
            else
                cause_q[k] <= (wr_i ? wdata_i[k] : cause_q[k]) | evt_i[k];
        end
    end

    assign cause_o = cause_q;

    // R2
    cause_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> ((cause_q & $past(cause_q)) == $past(cause_q)));
    // R4
    evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((cause_q & $past(evt_i)) == $past(evt_i)));
    // R3
    cause_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && evt_i == '0) |=> (cause_q == $past(wdata_i)));
endmodule

// File: rtl/pmirq_mask_reg.sv
// Mask register: one enable bit per source, where 1 enables the source.
// It changes only through software writes.
module pmirq_mask_reg #(
    parameter int unsigned SRC_N = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [SRC_N-1:0] wdata_i,
    output logic [SRC_N-1:0] mask_o
);
    logic [SRC_N-1:0] mask_q;

    // Mask storage: cleared at reset, loaded on a selected write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (wr_i)
            mask_q <= wdata_i;
    end

    assign mask_o = mask_q;

    // R5
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(mask_q));
endmodule

// File: rtl/pmirq_regport.sv
// Register port: decodes the strobe interface into per-register write enables
// and returns read data.
// Unmapped offsets read 0 and ignore writes. Bits above the source count read 0.
// Reads are combinational and have no side effects.
module pmirq_regport
    import pmirq_pkg::*;
#(
    parameter int unsigned SRC_N  = 7,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [SRC_N-1:0]  cause_i,
    input  logic [SRC_N-1:0]  mask_i,
    output logic              cause_wr_o,
    output logic              mask_wr_o,
    output logic [SRC_N-1:0]  wbits_o,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int unsigned PAD_W = DATA_W - SRC_N;

    logic hit_cause, hit_mask;
    logic unused_hi;

    assign hit_cause = (addr_i == ADDR_W'(CAUSE_OFS));
    assign hit_mask  = (addr_i == ADDR_W'(MASK_OFS));
    assign unused_hi = ^wdata_i[DATA_W-1:SRC_N];

    assign cause_wr_o = wr_i & hit_cause;
    assign mask_wr_o  = wr_i & hit_mask;
    assign wbits_o    = wdata_i[SRC_N-1:0];

    // Read multiplexer: zero-extended register value, or 0 when nothing is selected.
    always_comb begin
        rdata_o = '0;
        if (rd_i && hit_cause)
            rdata_o = {{PAD_W{1'b0}}, cause_i};
        else if (rd_i && hit_mask)
            rdata_o = {{PAD_W{1'b0}}, mask_i};
    end

    // R8
    unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_i || (!hit_cause && !hit_mask)) |-> (rdata_o == '0));
    // R5
    upper_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_o[DATA_W-1:SRC_N] == '0);
endmodule

// File: rtl/pmirq_unit.sv
// Top level of the power-management interrupt cause/mask unit.
// Combines the cause register, the mask register and the register port.
// Registers the OR of the enabled pending bits into one request for the parent.
// Assumes synchronous inputs and a synchronous active-low reset.
module pmirq_unit
    import pmirq_pkg::*;
#(
    parameter int unsigned N_SRC  = SRC_N,
    parameter int unsigned DW     = DATA_W,
    parameter int unsigned AW     = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N_SRC-1:0] evt_i,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    output logic          irq_o
);
    logic             cause_wr, mask_wr;
    logic [N_SRC-1:0] wbits, cause, mask;
    logic             irq_q;
    logic             pend_any;

    pmirq_regport #(.SRC_N(N_SRC), .DATA_W(DW), .ADDR_W(AW)) u_port (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (wr_en),
        .rd_i       (rd_en),
        .addr_i     (addr),
        .wdata_i    (wr_data),
        .cause_i    (cause),
        .mask_i     (mask),
        .cause_wr_o (cause_wr),
        .mask_wr_o  (mask_wr),
        .wbits_o    (wbits),
        .rdata_o    (rd_data)
    );

    pmirq_cause_reg #(.SRC_N(N_SRC)) u_cause (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (evt_i),
        .wr_i    (cause_wr),
        .wdata_i (wbits),
        .cause_o (cause)
    );

    pmirq_mask_reg #(.SRC_N(N_SRC)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (mask_wr),
        .wdata_i (wbits),
        .mask_o  (mask)
    );

    assign pend_any = |(cause & mask);

    // Request register: one cycle after the enabled pending set changes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else
            irq_q <= pend_any;
    end

    assign irq_o = irq_q;

    // R6
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cause & mask) != '0) |=> irq_o);
    // R6
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((cause & mask) == '0) |=> !irq_o);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!irq_o && cause == '0 && mask == '0));
endmodule

// File: tb/pmirq_unit_tb.sv
module pmirq_unit_tb;
    localparam logic [7:0] A_CAUSE = 8'h50;
    localparam logic [7:0] A_MASK  = 8'h54;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  evt_i = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        irq_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pmirq_unit u_dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rd_data;
        rd_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v, snap;
        logic        irq_before;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(A_CAUSE, v); check("R1 cause", v, 0);
        rd(A_MASK, v);  check("R1 mask", v, 0);
        check("R1 irq", {31'b0, irq_o}, 0);
        check("R8 idle rd_data", rd_data, 0);

        // R2 each event pulse latches and stays
        for (int k = 0; k < 7; k++) begin
            @(negedge clk); evt_i = 7'(1 << k);
            @(negedge clk); evt_i = '0;
            repeat (2) @(negedge clk);
            rd(A_CAUSE, v); check("R2 latch", v, 32'(1 << k));
            wr(A_CAUSE, 0);
        end

        // R3/R5 exhaustive mask x cause sweep, irq compared one cycle later (R6)
        for (int m = 0; m < 128; m++) begin
            wr(A_MASK, 32'hFFFF_FF00 | 32'(m));
            for (int c = 0; c < 128; c++) begin
                wr(A_CAUSE, 32'hABCD_0000 | 32'(c));
                @(negedge clk);
                check("R6 irq sweep", {31'b0, irq_o}, {31'b0, (c & m) != 0});
                if (m == 127 || m == 0) begin
                    rd(A_CAUSE, v); check("R3 cause readback", v, 32'(c));
                end
            end
            rd(A_MASK, v); check("R5 mask readback", v, 32'(m));
        end

        // R6 exact fall timing
        wr(A_MASK, 32'h01); wr(A_CAUSE, 32'h01);
        @(negedge clk);
        check("R6 irq high", {31'b0, irq_o}, 1);
        wr(A_CAUSE, 0);
        check("R6 irq one cycle after clear", {31'b0, irq_o}, 1);
        @(negedge clk);
        check("R6 irq low", {31'b0, irq_o}, 0);

        // R4 event collides with software write of 0
        wr(A_CAUSE, 32'h7F);
        @(negedge clk);
        wr_en = 1'b1; addr = A_CAUSE; wr_data = 0; evt_i = 7'h08;
        @(negedge clk);
        wr_en = 1'b0; evt_i = '0;
        rd(A_CAUSE, v); check("R4 event wins", v, 32'h08);

        // R7 reads leave cause and irq unchanged
        wr(A_MASK, 32'h08);
        @(negedge clk);
        irq_before = irq_o;
        for (int i = 0; i < 4; i++) begin
            rd(A_CAUSE, v); check("R7 repeated read", v, 32'h08);
        end
        @(negedge clk);
        check("R7 irq unchanged", {31'b0, irq_o}, {31'b0, irq_before});

        // R8 unmapped writes and reads
        wr(8'h58, 32'hFFFF_FFFF);
        wr(8'h51, 32'hFFFF_FFFF);
        rd(A_CAUSE, v); check("R8 cause untouched", v, 32'h08);
        rd(A_MASK, v);  check("R8 mask untouched", v, 32'h08);
        rd(8'h58, v);   check("R8 unmapped read", v, 0);

        // R5 upper bits ignored
        wr(A_MASK, 32'hFFFF_FFFF);
        rd(A_MASK, v); check("R5 upper bits", v, 32'h7F);

        // R9 lost-event window in read-modify-write clear
        wr(A_CAUSE, 0);
        rd(A_CAUSE, snap);
        @(negedge clk); evt_i = 7'h04;
        @(negedge clk); evt_i = '0;
        wr(A_CAUSE, snap & ~32'h01);
        rd(A_CAUSE, v); check("R9 event lost", v, 0);
        @(negedge clk);
        check("R9 irq dropped", {31'b0, irq_o}, 0);
        // same window, event still high during write: kept
        rd(A_CAUSE, snap);
        @(negedge clk);
        wr_en = 1'b1; addr = A_CAUSE; wr_data = snap; evt_i = 7'h04;
        @(negedge clk);
        wr_en = 1'b0; evt_i = '0;
        rd(A_CAUSE, v); check("R9 event kept when present", v, 32'h04);

        // R1 reset mid-run clears everything
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd(A_CAUSE, v); check("R1 cause after reset", v, 0);
        rd(A_MASK, v);  check("R1 mask after reset", v, 0);
        check("R1 irq after reset", {31'b0, irq_o}, 0);

        finish_run();
    end
endmodule